// File: doc/BRIEF.md
# Fixed-Frequency Current Chopper Timing Controller

This block sequences one motor winding through fixed-frequency current chopping. Every chopping period opens with a drive phase, in which the bridge pushes current through the winding in the direction given by the winding sign. An external comparator raises a trip bit when the winding current reaches its threshold. That bit is disregarded for a blanking window at the start of drive, so the window also acts as the minimum on-time. Once a trip is taken, drive stops and the winding stays in decay for the rest of the period.

Three decay styles can be selected: slow (both low-side switches recirculate), fast (bridge reversed until a zero-current detect bit arrives, then all switches off), and mixed. Mixed runs fast decay up to three quarters of the period and then slow decay, but only while the indexer reports a falling commanded current. With rising current it uses slow decay. The period and blanking lengths are derived from the system clock rate by parameters. The output is a four-bit gate command for the two half-bridges. Dead time and analog sensing are handled elsewhere.

Top module: `pwm_chopper`

## Requirements
- R1: While `rst` is high, `gate` is 4'b0000. After `rst` is released with `en` high, the first cycle is the start of a period in drive.
- R2: While `en` is low, `gate` is 4'b0000 and the period counter is held at its start, so the cycle after `en` rises is period cycle 0 in drive.
- R3: A period lasts PERIOD_CYC = CLK_HZ/PWM_HZ cycles (200 by default), and every period begins in drive, whatever state the previous period ended in.
- R4: `trip` is ignored in period cycles 0 to BLANK_CYC-1, where BLANK_CYC is the blanking time rounded up to whole clocks (38 by default). A trip sampled in cycle c ≥ BLANK_CYC (c ≤ PERIOD_CYC-2) gives decay from cycle c+1.
- R5: Once decay has begun, it lasts until the period ends. Releasing `trip` does not bring back drive.
- R6: `gate` = {hi1, lo1, hi2, lo2}. Drive with `sign_neg`=0 is 4'b1001 and with `sign_neg`=1 is 4'b0110.
- R7: Slow decay is 4'b0101 (both low sides on), regardless of sign.
- R8: Fast decay reverses the bridge (4'b0110 for positive sign, 4'b1001 for negative). A `zero_det` sampled high during fast decay in cycle c turns `gate` to 4'b0000 from c+1 to the end of the period. `zero_det` has no effect in drive or slow decay.
- R9: In mixed mode with `falling`=1, decay is fast until period cycle MIX_CYC = 3·PERIOD_CYC/4 (150) and slow from there. A trip taken in cycle MIX_CYC-1 or later goes straight to slow. A zero detect takes priority over the switch to slow.
- R10: In mixed mode with `falling`=0, the decay is slow.
- R11: `decay_sel` encoding: 2'b00 slow, 2'b01 mixed, 2'b10 and 2'b11 fast.
- R12: The high and low side of the same half-bridge are never commanded on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Winding enable; low forces gates off and restarts the period |
| decay_sel | input | 2 | Decay style select (R11 encoding) |
| trip | input | 1 | Current comparator trip bit |
| zero_det | input | 1 | Winding current near zero |
| falling | input | 1 | Commanded current is decreasing |
| sign_neg | input | 1 | Winding sign, 1 = negative direction |
| gate | output | 4 | Switch command {hi1, lo1, hi2, lo2} |

## Verification
Two cases can fall in the same cycle. In the first, a trip is accepted in mixed mode right at the three-quarter point: a trip raised in cycle 149 must produce slow decay with no fast cycle in between. In the second, a zero detect arrives in cycle 149, just as fast decay would change to slow, and it must win and give all switches off. The bench provokes both by placing trip and zero windows on exact cycles. A per-cycle scoreboard judges every gate command against the expected phase. The blanking edge is handled the same way, with one-cycle trip pulses at cycles 37 and 38.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        DM_SLOW  = 2'b00,
        DM_MIXED = 2'b01,
        DM_FAST  = 2'b10,
        DM_FAST2 = 2'b11
    } decay_sel_e;

    typedef enum logic [1:0] {
        PH_DRIVE = 2'd0,
        PH_FAST  = 2'd1,
        PH_SLOW  = 2'd2,
        PH_OFF   = 2'd3
    } phase_e;

    typedef struct packed {
        logic hi1;
        logic lo1;
        logic hi2;
        logic lo2;
    } gate_t;

    // whole clock cycles covering a time span, rounded up
    function automatic int unsigned span_cycles(longint unsigned clk_hz,
                                                longint unsigned span_ns);
        longint unsigned prod;
        prod = clk_hz * span_ns;
        return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

    function automatic gate_t gate_for(phase_e ph, logic neg);
        gate_t g;
        g = '0;
        unique case (ph)
            PH_DRIVE: begin
                g.hi1 = !neg; g.lo2 = !neg;
                g.hi2 = neg;  g.lo1 = neg;
            end
            PH_FAST: begin
                g.hi1 = neg;  g.lo2 = neg;
                g.hi2 = !neg; g.lo1 = !neg;
            end
            PH_SLOW: begin
                g.lo1 = 1'b1; g.lo2 = 1'b1;
            end
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int unsigned PERIOD = 200,
    localparam int unsigned CW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);

    assign last = (cnt == LAST_C);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (last)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST_C) |=> (cnt == '0));
endmodule

// File: rtl/chop_phase.sv
module chop_phase
    import chop_pkg::*;
#(
    parameter int unsigned PERIOD = 200,
    parameter int unsigned BLANK  = 38,
    parameter int unsigned MIX    = 150,
    localparam int unsigned CW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic          last,
    input  logic          trip,
    input  logic          zero_det,
    input  logic          falling,
    input  decay_sel_e    mode,
    output phase_e        phase
);
    localparam logic [CW-1:0] BLANK_C  = CW'(BLANK);
    localparam logic [CW-1:0] MIXPRE_C = CW'(MIX - 1);
    localparam logic [CW-1:0] LAST_C   = CW'(PERIOD - 1);

    logic   mix_q;
    logic   trip_ok;
    phase_e decay_pick;
    logic   pick_mix;

    assign trip_ok = trip && (cnt >= BLANK_C);

    // decay chosen at the moment a trip is accepted
    always_comb begin
        decay_pick = PH_FAST;
        pick_mix   = 1'b0;
        unique case (mode)
            DM_SLOW:  decay_pick = PH_SLOW;
            DM_MIXED: begin
                if (!falling || cnt >= MIXPRE_C) decay_pick = PH_SLOW;
                else begin
                    decay_pick = PH_FAST;
                    pick_mix   = 1'b1;
                end
            end
            default:  decay_pick = PH_FAST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= PH_DRIVE;
            mix_q <= 1'b0;
        end else if (last) begin
            phase <= PH_DRIVE;
            mix_q <= 1'b0;
        end else begin
            unique case (phase)
                PH_DRIVE: if (trip_ok) begin
                    phase <= decay_pick;
                    mix_q <= pick_mix;
                end
                PH_FAST: begin
                    if (zero_det)                      phase <= PH_OFF;
                    else if (mix_q && cnt == MIXPRE_C) phase <= PH_SLOW;
                end
                default: phase <= phase;
            endcase
        end
    end

    a_r4_blank_hold: assert property (@(posedge clk) disable iff (rst)
        (run && phase == PH_DRIVE && cnt < BLANK_C) |=> (phase == PH_DRIVE));

    a_r3_period_starts_drive: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST_C) |=> (phase == PH_DRIVE));

    a_r5_decay_hold: assert property (@(posedge clk) disable iff (rst)
        (run && phase != PH_DRIVE && cnt != LAST_C) |=> (phase != PH_DRIVE));

    a_r8_off_sticky: assert property (@(posedge clk) disable iff (rst)
        (run && phase == PH_OFF && cnt != LAST_C) |=> (phase == PH_OFF));
endmodule

// File: rtl/chop_gate.sv
module chop_gate
    import chop_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  phase_e phase,
    input  logic   neg,
    output gate_t  gate
);
    always_comb begin
        if (run) gate = gate_for(phase, neg);
        else     gate = '0;
    end

    a_r12_no_shoot: assert property (@(posedge clk) disable iff (rst)
        !(gate.hi1 && gate.lo1) && !(gate.hi2 && gate.lo2));

    a_r7_slow_lows: assert property (@(posedge clk) disable iff (rst)
        (run && phase == PH_SLOW) |-> (gate.lo1 && gate.lo2 && !gate.hi1 && !gate.hi2));
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
    import chop_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 10_000_000,
    parameter int unsigned PWM_HZ   = 50_000,
    parameter int unsigned BLANK_NS = 3750
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] decay_sel,
    input  logic       trip,
    input  logic       zero_det,
    input  logic       falling,
    input  logic       sign_neg,
    output logic [3:0] gate
);
    localparam int unsigned PERIOD_CYC = CLK_HZ / PWM_HZ;
    localparam int unsigned BLANK_CYC  = span_cycles(CLK_HZ, BLANK_NS);
    localparam int unsigned MIX_CYC    = (PERIOD_CYC * 3) / 4;
    localparam int unsigned CW         = $clog2(PERIOD_CYC);

    logic          run;
    logic [CW-1:0] cnt;
    logic          last;
    phase_e        phase;
    gate_t         g;

    assign run = en && !rst;

    chop_timer #(.PERIOD(PERIOD_CYC)) u_timer (
        .clk (clk),
        .rst (rst),
        .run (run),
        .cnt (cnt),
        .last(last)
    );

    chop_phase #(
        .PERIOD(PERIOD_CYC),
        .BLANK (BLANK_CYC),
        .MIX   (MIX_CYC)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .cnt     (cnt),
        .last    (last),
        .trip    (trip),
        .zero_det(zero_det),
        .falling (falling),
        .mode    (decay_sel_e'(decay_sel)),
        .phase   (phase)
    );

    chop_gate u_gate (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .phase(phase),
        .neg  (sign_neg),
        .gate (g)
    );

    assign gate = g;

    a_r2_idle_off: assert property (@(posedge clk)
        (!en || rst) |-> (gate == 4'b0000));
endmodule

// File: tb/sim_pwm_chopper.sv
module sim_pwm_chopper;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] decay_sel = 2'b00;
    logic       trip = 1'b0;
    logic       zero_det = 1'b0;
    logic       falling = 1'b0;
    logic       sign_neg = 1'b0;
    logic [3:0] gate;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] exp_q[$];
    string      req_q[$];

    localparam int PER = 200;
    localparam int BLK = 38;
    localparam int MIXP = 150;

    always #2 clk = ~clk;

    pwm_chopper u0 (
        .clk(clk), .rst(rst), .en(en), .decay_sel(decay_sel), .trip(trip),
        .zero_det(zero_det), .falling(falling), .sign_neg(sign_neg), .gate(gate)
    );

    // monitor: compare each produced gate word against the scoreboard
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            checks++;
            if (gate !== e) begin
                fails++;
                $display("FAIL %s: gate=%b expected=%b at %0t", r, gate, e, $time);
            end
        end
    end

    // 0 drive, 1 fast, 2 slow, 3 off
    function automatic logic [3:0] enc(int ph, logic neg);
        case (ph)
            0: return neg ? 4'b0110 : 4'b1001;
            1: return neg ? 4'b1001 : 4'b0110;
            2: return 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic idle(input int n, input logic r, input logic e, input string req);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rst = r; en = e; trip = 1'b1; zero_det = 1'b1;
            exp_q.push_back(4'b0000); req_q.push_back(req);
        end
    endtask

    // one full period from cycle 0; trip high in [tlo,thi], zero high from zat
    task automatic run_period(input logic [1:0] md, input logic neg, input logic dec,
                              input int tlo, input int thi, input int zat,
                              input string req);
        int t;
        int z;
        t = -1;
        for (int c = BLK; c <= PER - 2; c++)
            if (t < 0 && c >= tlo && c <= thi) t = c;
        z = (zat > t + 1) ? zat : t + 1;
        for (int c = 0; c < PER; c++) begin
            int ph;
            @(posedge clk); #1;
            rst = 1'b0; en = 1'b1; decay_sel = md; sign_neg = neg; falling = dec;
            trip = (c >= tlo && c <= thi);
            zero_det = (c >= zat);
            if (t < 0 || c <= t) ph = 0;
            else if (md == 2'b00) ph = 2;
            else if (md[1]) ph = (c > z) ? 3 : 1;
            else if (!dec || t >= MIXP - 1) ph = 2;
            else if (z <= MIXP - 1) ph = (c > z) ? 3 : 1;
            else ph = (c >= MIXP) ? 2 : 1;
            exp_q.push_back(enc(ph, neg));
            req_q.push_back(req);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3, 1'b1, 1'b1, "R1 reset");
        idle(5, 1'b0, 1'b0, "R2 disabled");
        // trip held from cycle 10: blanking defers it to 38 (R4), slow (R7, R11)
        run_period(2'b00, 1'b0, 1'b0, 10, 199, 999, "R4 blank/R7 slow");
        // slow, zero detect ignored in slow (R8)
        run_period(2'b00, 1'b0, 1'b0, 100, 199, 0, "R7 slow zero ignored R8");
        // no trip: drive whole period (R3, R6)
        run_period(2'b00, 1'b0, 1'b0, 999, 999, 999, "R3 full drive R6");
        // fast then zero detect
        run_period(2'b10, 1'b0, 1'b0, 50, 199, 120, "R8 fast/off");
        // fast, trip pulse only (R5), zero never
        run_period(2'b10, 1'b0, 1'b0, 60, 61, 999, "R5 decay hold");
        // zero high in drive, trip later: fast one cycle then off
        run_period(2'b10, 1'b0, 1'b0, 60, 199, 0, "R8 zero in drive");
        // negative sign drive/fast, alternate fast code (R11)
        run_period(2'b11, 1'b1, 1'b0, 50, 199, 999, "R6 neg R11 fast");
        // mixed falling: fast then slow at 150
        run_period(2'b01, 1'b0, 1'b1, 60, 199, 999, "R9 mixed");
        // mixed falling, trip late -> slow directly
        run_period(2'b01, 1'b0, 1'b1, 170, 199, 999, "R9 late trip");
        // mixed falling, trip exactly at 149 collides with mix point
        run_period(2'b01, 1'b1, 1'b1, 149, 149, 999, "R9 trip at mix point");
        // mixed falling, zero at 149 wins over switch to slow
        run_period(2'b01, 1'b0, 1'b1, 60, 199, 149, "R9 zero at mix point");
        // mixed falling, early zero
        run_period(2'b01, 1'b0, 1'b1, 60, 199, 100, "R9 mixed zero");
        // mixed rising -> slow
        run_period(2'b01, 1'b0, 1'b0, 60, 199, 999, "R10 mixed rising");
        // blanking edge: pulse at 37 ignored, pulse at 38 taken
        run_period(2'b00, 1'b0, 1'b0, 37, 37, 999, "R4 pulse at 37");
        run_period(2'b00, 1'b0, 1'b0, 38, 38, 999, "R4 pulse at 38");
        // disable mid-period, then fresh period (R2)
        run_period(2'b10, 1'b0, 1'b0, 50, 199, 999, "R8 before disable");
        idle(4, 1'b0, 1'b0, "R2 disabled mid");
        run_period(2'b00, 1'b1, 1'b0, 90, 199, 999, "R2 restart");
        // reset during operation then restart (R1)
        idle(2, 1'b1, 1'b1, "R1 reset again");
        run_period(2'b10, 1'b1, 1'b0, 40, 199, 80, "R1 restart");
        @(posedge clk); #1; en = 1'b0;
        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule